// File: doc/BRIEF.md
# Indexed Signed Four-Way Dot-Product Accumulator

This block is a vector datapath for packed-integer dot products. The first source vector is split into accumulator-sized lanes. Each lane is read as four signed narrow integers. Each 128-bit segment of the second source vector contributes one group of four signed narrow integers, and that group is chosen by a small index. The chosen group is broadcast to every accumulator lane in the same segment. The four products of each lane are widened, summed and added to the matching lane of the accumulator vector. Every lane is updated on every operation.

There are two widths, chosen per operation. In byte mode, 8-bit inputs feed 32-bit accumulators and a segment holds four lanes. In halfword mode, 16-bit inputs feed 64-bit accumulators and a segment holds two lanes. The vector width is a parameter that must be a multiple of 128 bits, and all segments are computed in parallel.

An operation is accepted with a valid/ready handshake. The result comes back a fixed number of cycles later on a registered output, which is held until the consumer takes it.

Top module: `grpdot_accum`

## Requirements
- R1: With wideMode=0, each 32-bit lane e (bits 32e+31..32e, lane 0 in the least significant bits) of accOut equals accIn lane e plus the sum over i=0..3 of srcA byte (4e+i) times the selected srcB byte group element i. Both bytes are treated as signed two's complement.
- R2: With wideMode=1, each 64-bit lane e of accOut equals accIn lane e plus the sum over i=0..3 of signed srcA halfword (4e+i) times element i of the selected signed srcB halfword group.
- R3: The srcB group for lane e is taken from the 128-bit segment that holds lane e. In byte mode it is the 32-bit word at position grpSel (0..3) inside that segment. In halfword mode it is the 64-bit word at position grpSel[0] (0..1).
- R4: In halfword mode grpSel[1] has no effect on the result.
- R5: Accumulation wraps modulo 2^32 (byte mode) or 2^64 (halfword mode), with no saturation.
- R6: The operation is unpredicated: every accumulator lane of accOut is written on every operation.
- R7: After a handshake (inValid and inReady high at a rising edge), outValid is low at the next edge and high at the edge after that, whatever the operand values.
- R8: While outValid is high and outReady is low, outValid stays high and accOut holds its value. inReady is low whenever an operation is in flight or a result is waiting.
- R9: After reset, outValid is 0 and inReady is 1. Once outReady takes a result, the block returns to that idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and mode are presented |
| inReady | output | 1 | Block can accept an operation |
| wideMode | input | 1 | 0: 8-bit into 32-bit, 1: 16-bit into 64-bit |
| grpSel | input | 2 | Group index within each 128-bit segment of srcB |
| srcA | input | VEC_BITS | First source vector of narrow elements |
| srcB | input | VEC_BITS | Second source vector, indexed per segment |
| accIn | input | VEC_BITS | Accumulator vector to add into |
| outValid | output | 1 | accOut holds a finished result |
| outReady | input | 1 | Consumer takes the result |
| accOut | output | VEC_BITS | Updated accumulator vector |

## Verification
The hardest situation to reach is one where the index selection, the segment boundary and the wrap all matter at once. A wrong group, or a group taken from the wrong segment, is hidden whenever the words of srcB are equal or the sums stay small. The stimulus therefore fills srcB with a distinct value in every word of every segment and walks all four byte-mode indices on that pattern. It also drives the most negative narrow values against accumulators near their signed limits, so that both the sign extension and the wrap show up in the result. Random operations with random stall lengths on outReady then mix both modes, with both values of the unused index bit, against a bench reference model.

// File: rtl/grpdot_pkg.sv
package grpdot_pkg;
  localparam int SEG_BITS = 128;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_HOLD = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic loadOps;
    logic capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/grpdot_lane.sv
module grpdot_lane #(
  parameter int NARROW = 8
) (
  input  logic [4*NARROW-1:0] aVec,
  input  logic [4*NARROW-1:0] bVec,
  input  logic [4*NARROW-1:0] accPrev,
  output logic [4*NARROW-1:0] sum
);
  localparam int ACCW  = 4 * NARROW;
  localparam int PRODW = 2 * NARROW;

  logic signed [PRODW-1:0] prod [4];
  logic [ACCW-1:0] prodExt [4];

  for (genvar i = 0; i < 4; i++) begin : g_mul
    assign prod[i] = $signed(aVec[i*NARROW +: NARROW]) * $signed(bVec[i*NARROW +: NARROW]);
    assign prodExt[i] = {{(ACCW-PRODW){prod[i][PRODW-1]}}, prod[i]};
  end

  logic [ACCW-1:0] pairLo, pairHi;
  assign pairLo = prodExt[0] + prodExt[1];
  assign pairHi = prodExt[2] + prodExt[3];
  assign sum = accPrev + pairLo + pairHi;
endmodule

// File: rtl/grpdot_ctrl.sv
module grpdot_ctrl
  import grpdot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  ctrlState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.loadOps = 1'b0;
    strobe.capture = 1'b0;
    unique case (state)
      ST_IDLE: if (inValid) begin
        strobe.loadOps = 1'b1;
        stateNext      = ST_CALC;
      end
      ST_CALC: begin
        strobe.capture = 1'b1;
        stateNext      = ST_HOLD;
      end
      ST_HOLD: if (outReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_HOLD);
endmodule

// File: rtl/grpdot_path.sv
module grpdot_path
  import grpdot_pkg::*;
#(
  parameter int VEC_BITS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                wideMode,
  input  logic [1:0]          grpSel,
  input  logic [VEC_BITS-1:0] srcA,
  input  logic [VEC_BITS-1:0] srcB,
  input  logic [VEC_BITS-1:0] accIn,
  output logic [VEC_BITS-1:0] accOut
);
  localparam int SEG_COUNT = VEC_BITS / SEG_BITS;
  localparam int LANES8    = SEG_BITS / 32;
  localparam int LANES16   = SEG_BITS / 64;

  logic [VEC_BITS-1:0] opA, opB, opC;
  logic                modeQ;
  logic [1:0]          selQ;
  logic [VEC_BITS-1:0] resNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA   <= '0;
      opB   <= '0;
      opC   <= '0;
      modeQ <= 1'b0;
      selQ  <= '0;
    end else if (strobe.loadOps) begin
      opA   <= srcA;
      opB   <= srcB;
      opC   <= accIn;
      modeQ <= wideMode;
      selQ  <= grpSel;
    end
  end

  logic [6:0] off8, off16;
  assign off8  = {selQ, 5'b0};
  assign off16 = {selQ[0], 6'b0};

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    logic [SEG_BITS-1:0] segA, segB, segC, byteRes, halfRes;
    logic [31:0] grp8;
    logic [63:0] grp16;

    assign segA  = opA[g*SEG_BITS +: SEG_BITS];
    assign segB  = opB[g*SEG_BITS +: SEG_BITS];
    assign segC  = opC[g*SEG_BITS +: SEG_BITS];
    assign grp8  = segB[off8 +: 32];
    assign grp16 = segB[off16 +: 64];

    for (genvar l = 0; l < LANES8; l++) begin : g_byte
      grpdot_lane #(.NARROW(8)) u_lane (
        .aVec   (segA[l*32 +: 32]),
        .bVec   (grp8),
        .accPrev(segC[l*32 +: 32]),
        .sum    (byteRes[l*32 +: 32])
      );
    end

    for (genvar l = 0; l < LANES16; l++) begin : g_half
      grpdot_lane #(.NARROW(16)) u_lane (
        .aVec   (segA[l*64 +: 64]),
        .bVec   (grp16),
        .accPrev(segC[l*64 +: 64]),
        .sum    (halfRes[l*64 +: 64])
      );
    end

    assign resNext[g*SEG_BITS +: SEG_BITS] = modeQ ? halfRes : byteRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               accOut <= '0;
    else if (strobe.capture) accOut <= resNext;
  end
endmodule

// File: rtl/grpdot_accum.sv
module grpdot_accum
  import grpdot_pkg::*;
#(
  parameter int VEC_BITS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic                wideMode,
  input  logic [1:0]          grpSel,
  input  logic [VEC_BITS-1:0] srcA,
  input  logic [VEC_BITS-1:0] srcB,
  input  logic [VEC_BITS-1:0] accIn,
  output logic                outValid,
  input  logic                outReady,
  output logic [VEC_BITS-1:0] accOut
);
  ctrlStrobe_t strobe;

  grpdot_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  grpdot_path #(.VEC_BITS(VEC_BITS)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wideMode(wideMode),
    .grpSel  (grpSel),
    .srcA    (srcA),
    .srcB    (srcB),
    .accIn   (accIn),
    .accOut  (accOut)
  );
endmodule

// File: rtl/grpdot_checker.sv
module grpdot_checker #(
  parameter int VEC_BITS = 256
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inReady,
  input logic                outValid,
  input logic                outReady,
  input logic [VEC_BITS-1:0] accOut
);
  a_r7_gap_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !outValid);

  a_r7_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> ##2 outValid);

  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(accOut)));

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  a_r9_drop_on_take: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady));

  a_r9_idle_after_take: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (inReady && !outValid));
endmodule

bind grpdot_accum grpdot_checker #(.VEC_BITS(VEC_BITS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .accOut  (accOut)
);

// File: tb/sim_grpdot_accum.sv
`timescale 1ns/1ps
module sim_grpdot_accum;
  localparam int VB = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic wideMode = 1'b0;
  logic [1:0] grpSel = '0;
  logic [VB-1:0] srcA = '0, srcB = '0, accIn = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [VB-1:0] accOut;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  grpdot_accum #(.VEC_BITS(VB)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .wideMode(wideMode), .grpSel(grpSel), .srcA(srcA), .srcB(srcB),
    .accIn(accIn), .outValid(outValid), .outReady(outReady), .accOut(accOut)
  );

  function automatic logic [VB-1:0] refDot(input logic [VB-1:0] a, b, c,
                                           input logic wide, input logic [1:0] idx);
    logic [VB-1:0] r;
    r = '0;
    if (!wide) begin
      for (int e = 0; e < VB/32; e++) begin
        int s;
        logic [31:0] acc;
        s   = (e / 4) * 4 + int'(idx);
        acc = c[e*32 +: 32];
        for (int i = 0; i < 4; i++) begin
          longint p;
          p   = longint'($signed(a[(4*e+i)*8 +: 8])) * longint'($signed(b[(4*s+i)*8 +: 8]));
          acc = acc + p[31:0];
        end
        r[e*32 +: 32] = acc;
      end
    end else begin
      for (int e = 0; e < VB/64; e++) begin
        int s;
        logic [63:0] acc;
        s   = (e / 2) * 2 + int'(idx[0]);
        acc = c[e*64 +: 64];
        for (int i = 0; i < 4; i++) begin
          longint p;
          p   = longint'($signed(a[(4*e+i)*16 +: 16])) * longint'($signed(b[(4*s+i)*16 +: 16]));
          acc = acc + 64'(p);
        end
        r[e*64 +: 64] = acc;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VB-1:0] act, input logic [VB-1:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [VB-1:0] randVec();
    logic [VB-1:0] v;
    for (int w = 0; w < VB/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic runOp(input logic [VB-1:0] a, b, c, input logic wide,
                       input logic [1:0] idx, input int stall, input string req,
                       output logic [VB-1:0] got);
    logic [VB-1:0] exp;
    exp = refDot(a, b, c, wide, idx);
    @(negedge clk);
    check(inReady === 1'b1, "R9", "idle before op", VB'(inReady), VB'(1));
    srcA = a; srcB = b; accIn = c; wideMode = wide; grpSel = idx; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    srcA = '0; srcB = '0; accIn = '0;
    check(outValid === 1'b0, "R7", "gap cycle", VB'(outValid), VB'(0));
    check(inReady === 1'b0, "R8", "busy after accept", VB'(inReady), VB'(0));
    @(negedge clk);
    check(outValid === 1'b1, "R7", "valid at fixed latency", VB'(outValid), VB'(1));
    check(accOut === exp, req, "result", accOut, exp);
    got = accOut;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(outValid === 1'b1 && accOut === got, "R8", "hold while stalled", accOut, got);
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(outValid === 1'b0 && inReady === 1'b1, "R9", "idle after take",
          VB'({outValid, inReady}), VB'(2'b01));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [VB-1:0] a, b, c, got, got2, segPat;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R9", "reset outValid", VB'(outValid), VB'(0));
    check(inReady === 1'b1, "R9", "reset inReady", VB'(inReady), VB'(1));
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R9", "idle after reset",
          VB'({outValid, inReady}), VB'(2'b01));

    // R5/R1: most negative bytes, accumulators at the signed limit
    a = {VB/8{8'h80}};
    c = {VB/32{32'h7FFF_FFFF}};
    runOp(a, a, c, 1'b0, 2'd3, 1, "R5", got);
    check(got[31:0] === 32'h8000_FFFF, "R5", "byte wrap lane0", VB'(got[31:0]), VB'(32'h8000_FFFF));

    // R5/R2: most negative halfwords, accumulator all ones
    a = {VB/16{16'h8000}};
    c = {VB{1'b1}};
    runOp(a, a, c, 1'b1, 2'd1, 0, "R5", got);
    check(got[63:0] === 64'h0000_0000_FFFF_FFFF, "R5", "half wrap lane0",
          VB'(got[63:0]), VB'(64'h0000_0000_FFFF_FFFF));

    // R3/R6: distinct word in every segment position, walk all indices
    for (int w = 0; w < VB/32; w++) segPat[w*32 +: 32] = {4{8'(w + 1)}};
    a = {VB/8{8'h01}};
    for (int ix = 0; ix < 4; ix++) begin
      runOp(a, segPat, '0, 1'b0, 2'(ix), 0, "R3", got);
      for (int e = 0; e < VB/32; e++) begin
        logic [31:0] want;
        want = 32'(4 * ((e / 4) * 4 + ix + 1));
        check(got[e*32 +: 32] === want, "R6", "every lane written from own segment",
              VB'(got[e*32 +: 32]), VB'(want));
      end
    end

    // R4: halfword mode, grpSel bit 1 toggled gives the same result
    a = randVec(); b = randVec(); c = randVec();
    runOp(a, b, c, 1'b1, 2'd0, 0, "R2", got);
    runOp(a, b, c, 1'b1, 2'd2, 2, "R4", got2);
    check(got2 === got, "R4", "grpSel[1] ignored in halfword mode", got2, got);
    runOp(a, b, c, 1'b1, 2'd3, 0, "R4", got2);
    runOp(a, b, c, 1'b1, 2'd1, 0, "R3", got);
    check(got2 === got, "R4", "grpSel[1] ignored, index 1", got2, got);

    // R1/R2 random mix with random stalls
    for (int n = 0; n < 40; n++) begin
      logic wide;
      wide = 1'($urandom);
      a = randVec(); b = randVec(); c = randVec();
      runOp(a, b, c, wide, 2'($urandom), int'($urandom % 4), wide ? "R2" : "R1", got);
    end

    finishRun();
  end
endmodule